// File: doc/BRIEF.md
# Pooled Partition Allocator with Per-Core Floor and Ceiling

This block is the central arbiter for a shared structure that is split into equal, self-contained partitions, such as a register file or a reorder buffer built in slices. Four cores draw partitions from one pool. Each partition belongs to at most one core at a time. A core asks for one more partition when its local share fills. It hands a partition back once that partition has drained.

The allocator tracks unowned partitions as a free bit vector. Each cycle it grants at most one partition, always the lowest-indexed free one, to one of the requesting cores. A rotating-priority arbiter picks the core. Each core has a floor (`MIN_PARTS`) that it is never shrunk below and a ceiling (`MAX_PARTS`) that it is never grown past. The ownership map is decoded into a one-hot core-select vector per partition, which drives the steering multiplexers in front of each partition.

At reset, core c owns partitions c*MIN_PARTS to c*MIN_PARTS+MIN_PARTS-1, and every other partition is free. The pool must hold at least NUM_CORES*MIN_PARTS partitions and no more than 64.

Top module: `pool_partition_alloc`

## Requirements
- R1: After reset, each core's count equals MIN_PARTS, and partition p < NUM_CORES*MIN_PARTS is owned by core p/MIN_PARTS. All higher partitions are free, and free_count_o equals NUM_PARTS - NUM_CORES*MIN_PARTS.
- R2: In a grant cycle, grant_o is one-hot and grant_part_o names the lowest-indexed free partition. One cycle later, that partition is owned by the granted core, and that core's count is one higher.
- R3: A core whose count equals MAX_PARTS receives no grant, even while it requests.
- R4: When free_count_o is zero, grant_o is all zero.
- R5: Among eligible requesters, priority rotates. After a grant to core k, the search starts at core k+1, wrapping after core NUM_CORES-1. The first search after reset starts at core 0.
- R6: A release from a core that owns the named partition and is above its floor frees the partition on the next cycle. The core's count drops by one, and free_count_o rises by one.
- R7: A release from a core whose count equals MIN_PARTS is ignored: ownership, counts and free_count_o are unchanged, and rel_err_o stays low.
- R8: A release that names a partition not owned by the releasing core makes rel_err_o high for exactly the next cycle and changes no ownership or count.
- R9: A release and a grant in the same cycle both take effect. The partition released in that cycle is never the one granted in that cycle.
- R10: The sum of all core counts plus free_count_o always equals NUM_PARTS, and free_count_o always equals the number of unowned partitions.
- R11: part_sel_o[p*NUM_CORES +: NUM_CORES] is the one-hot code of partition p's owner when the partition is owned, and zero when it is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_i | input | NUM_CORES | Per-core request for one more partition |
| rel_valid_i | input | 1 | A release is presented this cycle |
| rel_core_i | input | CW | Core that is releasing |
| rel_part_i | input | PW | Partition being released |
| grant_o | output | NUM_CORES | One-hot core granted this cycle |
| grant_part_o | output | PW | Partition granted this cycle |
| owner_valid_o | output | NUM_PARTS | Bit p set when partition p is owned |
| owner_o | output | NUM_PARTS*CW | Owning core of each partition, CW bits per partition |
| part_sel_o | output | NUM_PARTS*NUM_CORES | One-hot core select per partition, zero when free |
| core_count_o | output | NUM_CORES*NW | Partitions owned by each core, NW bits per core |
| free_count_o | output | NW | Number of free partitions |
| rel_err_o | output | 1 | Pulse: the previous cycle's release named a partition the core did not own |

## Verification
A corrupted ownership bit shows up on owner_valid_o and part_sel_o on the cycle after the faulty update. It also shows up on the first later grant, which skips or reuses the wrong partition. A count register that drifts breaks the balance between core_count_o and free_count_o at once. It then lets a core pass its ceiling or fall below its floor at the next request or release. A rotating pointer that advances wrongly changes which core wins the next contested cycle, so the bench runs contested requests over several cycles and checks each winner in turn.

// File: rtl/pool_pkg.sv
package pool_pkg;

  // Widest bit vector the helper functions accept; the pool must fit in it.
  localparam int VEC_W = 64;

  // Outcome of a release request after it has been checked against state.
  typedef enum logic [1:0] {
    REL_NONE      = 2'd0,
    REL_RETURN    = 2'd1,
    REL_AT_FLOOR  = 2'd2,
    REL_NOT_OWNED = 2'd3
  } rel_kind_e;

  // Number of set bits.
  function automatic int pop_count(input logic [VEC_W-1:0] v);
    int n;
    n = 0;
    for (int i = 0; i < VEC_W; i++) n += 32'(v[i]);
    return n;
  endfunction

  // Index of the lowest set bit, -1 if none.
  function automatic int lowest_set(input logic [VEC_W-1:0] v);
    int idx;
    idx = -1;
    for (int i = VEC_W - 1; i >= 0; i--) if (v[i]) idx = i;
    return idx;
  endfunction

  // First set bit among the low n bits, searching upward from start and
  // wrapping; -1 if none.
  function automatic int rr_pick(input logic [VEC_W-1:0] v, input int n, input int start);
    int res;
    int idx;
    res = -1;
    for (int k = 0; k < VEC_W; k++) begin
      if (k < n) begin
        idx = start + k;
        if (idx >= n) idx = idx - n;
        if (v[idx] && res < 0) res = idx;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/pool_rr_arbiter.sv
module pool_rr_arbiter #(
  parameter int N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         elig_i,
  output logic [N-1:0]         gnt_o,
  output logic                 gnt_valid_o,
  output logic [$clog2(N)-1:0] gnt_idx_o
);
  import pool_pkg::*;

  localparam int IW = $clog2(N);

  logic [IW-1:0] ptr_q;
  int            pick;

  always_comb begin
    pick        = rr_pick(VEC_W'(elig_i), N, int'(ptr_q));
    gnt_valid_o = (pick >= 0);
    gnt_idx_o   = gnt_valid_o ? IW'(pick) : '0;
    gnt_o       = gnt_valid_o ? (N'(1) << gnt_idx_o) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (gnt_valid_o) begin
      ptr_q <= (int'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + IW'(1);
    end
  end

endmodule

// File: rtl/pool_free_scan.sv
module pool_free_scan #(
  parameter int P = 16
) (
  input  logic [P-1:0]           owned_i,
  output logic                   any_o,
  output logic [$clog2(P)-1:0]   low_o,
  output logic [$clog2(P+1)-1:0] cnt_o
);
  import pool_pkg::*;

  localparam int PW = $clog2(P);
  localparam int NW = $clog2(P + 1);

  logic [P-1:0] free_vec;
  int           low;

  always_comb begin
    free_vec = ~owned_i;
    low      = lowest_set(VEC_W'(free_vec));
    any_o    = (low >= 0);
    low_o    = any_o ? PW'(low) : '0;
    cnt_o    = NW'(pop_count(VEC_W'(free_vec)));
  end

endmodule

// File: rtl/pool_owner_map.sv
module pool_owner_map #(
  parameter int P   = 16,
  parameter int C   = 4,
  parameter int MIN = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take_i,
  input  logic [$clog2(P)-1:0] take_part_i,
  input  logic [$clog2(C)-1:0] take_core_i,
  input  logic                 drop_i,
  input  logic [$clog2(P)-1:0] drop_part_i,
  output logic [P-1:0]         valid_o,
  output logic [P*$clog2(C)-1:0] owner_o,
  output logic [P*C-1:0]       sel_o
);
  localparam int PW = $clog2(P);
  localparam int CW = $clog2(C);

  for (genvar p = 0; p < P; p++) begin : g_part
    logic          vld_q;
    logic [CW-1:0] own_q;

    if (p < C * MIN) begin : g_boot_owned
      localparam logic [CW-1:0] BOOT_OWNER = CW'(p / MIN);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b1;
          own_q <= BOOT_OWNER;
        end else if (take_i && take_part_i == PW'(p)) begin
          vld_q <= 1'b1;
          own_q <= take_core_i;
        end else if (drop_i && drop_part_i == PW'(p)) begin
          vld_q <= 1'b0;
        end
      end
    end else begin : g_boot_free
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
          own_q <= '0;
        end else if (take_i && take_part_i == PW'(p)) begin
          vld_q <= 1'b1;
          own_q <= take_core_i;
        end else if (drop_i && drop_part_i == PW'(p)) begin
          vld_q <= 1'b0;
        end
      end
    end

    // Decoder feeding the per-partition access multiplexer.
    always_comb begin
      valid_o[p]             = vld_q;
      owner_o[p*CW +: CW]    = own_q;
      sel_o[p*C +: C]        = vld_q ? (C'(1) << own_q) : '0;
    end
  end

endmodule

// File: rtl/pool_partition_alloc.sv
module pool_partition_alloc #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PARTS = 16,
  parameter int MIN_PARTS = 2,
  parameter int MAX_PARTS = 6,
  localparam int CW = $clog2(NUM_CORES),
  localparam int PW = $clog2(NUM_PARTS),
  localparam int NW = $clog2(NUM_PARTS + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_CORES-1:0]      req_i,
  input  logic                      rel_valid_i,
  input  logic [CW-1:0]             rel_core_i,
  input  logic [PW-1:0]             rel_part_i,
  output logic [NUM_CORES-1:0]      grant_o,
  output logic [PW-1:0]             grant_part_o,
  output logic [NUM_PARTS-1:0]      owner_valid_o,
  output logic [NUM_PARTS*CW-1:0]   owner_o,
  output logic [NUM_PARTS*NUM_CORES-1:0] part_sel_o,
  output logic [NUM_CORES*NW-1:0]   core_count_o,
  output logic [NW-1:0]             free_count_o,
  output logic                      rel_err_o
);
  import pool_pkg::*;

  localparam logic [NW-1:0] MIN_N  = NW'(MIN_PARTS);
  localparam logic [NW-1:0] MAX_N  = NW'(MAX_PARTS);
  localparam logic [NW-1:0] BOOT_FREE = NW'(NUM_PARTS - NUM_CORES * MIN_PARTS);

  // Named internal events, also observed by the bound checker.
  logic                 scan_any;
  logic [PW-1:0]        scan_low;
  logic [NW-1:0]        scan_cnt_w;
  logic [NUM_CORES-1:0] elig_w;
  logic                 gnt_valid_w;
  logic [CW-1:0]        gnt_idx_w;
  logic                 rel_in_range;
  logic                 rel_owned;
  logic                 drop_en;
  rel_kind_e            rel_kind;

  logic [NW-1:0] cnt_q [NUM_CORES];
  logic [NW-1:0] free_q;
  logic          err_q;

  pool_free_scan #(.P(NUM_PARTS)) u_scan (
    .owned_i (owner_valid_o),
    .any_o   (scan_any),
    .low_o   (scan_low),
    .cnt_o   (scan_cnt_w)
  );

  // A core may compete only while below its ceiling and the pool has space.
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_elig
    assign elig_w[c] = req_i[c] && (cnt_q[c] < MAX_N) && scan_any;
  end

  pool_rr_arbiter #(.N(NUM_CORES)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .elig_i      (elig_w),
    .gnt_o       (grant_o),
    .gnt_valid_o (gnt_valid_w),
    .gnt_idx_o   (gnt_idx_w)
  );

  assign grant_part_o = scan_low;

  // Release classification.
  always_comb begin
    rel_in_range = ({1'b0, rel_part_i} < (PW+1)'(NUM_PARTS));
    rel_owned    = rel_in_range && owner_valid_o[rel_part_i] &&
                   (owner_o[rel_part_i*CW +: CW] == rel_core_i);
    if (!rel_valid_i)                   rel_kind = REL_NONE;
    else if (!rel_owned)                rel_kind = REL_NOT_OWNED;
    else if (cnt_q[rel_core_i] == MIN_N) rel_kind = REL_AT_FLOOR;
    else                                rel_kind = REL_RETURN;
    drop_en = (rel_kind == REL_RETURN);
  end

  pool_owner_map #(.P(NUM_PARTS), .C(NUM_CORES), .MIN(MIN_PARTS)) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .take_i      (gnt_valid_w),
    .take_part_i (scan_low),
    .take_core_i (gnt_idx_w),
    .drop_i      (drop_en),
    .drop_part_i (rel_part_i),
    .valid_o     (owner_valid_o),
    .owner_o     (owner_o),
    .sel_o       (part_sel_o)
  );

  // Per-core counts, updated incrementally from grant and release.
  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cnt
    logic add_one;
    logic sub_one;
    assign add_one = grant_o[c];
    assign sub_one = drop_en && (rel_core_i == CW'(c));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q[c] <= MIN_N;
      else        cnt_q[c] <= cnt_q[c] + NW'(add_one) - NW'(sub_one);
    end
    assign core_count_o[c*NW +: NW] = cnt_q[c];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= BOOT_FREE;
      err_q  <= 1'b0;
    end else begin
      free_q <= free_q - NW'(gnt_valid_w) + NW'(drop_en);
      err_q  <= (rel_kind == REL_NOT_OWNED);
    end
  end

  assign free_count_o = free_q;
  assign rel_err_o    = err_q;

endmodule

// File: rtl/pool_alloc_chk.sv
module pool_alloc_chk #(
  parameter int NUM_CORES = 4,
  parameter int NUM_PARTS = 16,
  parameter int MIN_PARTS = 2,
  parameter int MAX_PARTS = 6,
  localparam int CW = $clog2(NUM_CORES),
  localparam int PW = $clog2(NUM_PARTS),
  localparam int NW = $clog2(NUM_PARTS + 1)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [NUM_CORES-1:0]           grant_o,
  input logic [PW-1:0]                  grant_part_o,
  input logic [NUM_PARTS-1:0]           owner_valid_o,
  input logic [NUM_PARTS*CW-1:0]        owner_o,
  input logic [NUM_PARTS*NUM_CORES-1:0] part_sel_o,
  input logic [NUM_CORES*NW-1:0]        core_count_o,
  input logic [NW-1:0]                  free_count_o,
  input logic                           rel_err_o,
  input logic [NW-1:0]                  scan_cnt_w,
  input logic [1:0]                     rel_kind
);
  logic          seen_q;
  logic [PW-1:0] last_part_q;
  logic [CW-1:0] last_core_q;
  int            total;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q      <= 1'b0;
      last_part_q <= '0;
      last_core_q <= '0;
    end else begin
      seen_q      <= |grant_o;
      last_part_q <= grant_part_o;
      last_core_q <= '0;
      for (int c = 0; c < NUM_CORES; c++) if (grant_o[c]) last_core_q <= CW'(c);
    end
  end

  always_comb begin
    total = int'(free_count_o);
    for (int c = 0; c < NUM_CORES; c++) total += int'(core_count_o[c*NW +: NW]);
  end

  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_grant_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> (owner_valid_o[last_part_q] &&
                owner_o[last_part_q*CW +: CW] == last_core_q));

  p_empty_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (free_count_o == '0) |-> (grant_o == '0));

  p_conserve_r10: assert property (@(posedge clk) disable iff (!rst_n)
    total == NUM_PARTS);

  p_free_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    free_count_o == scan_cnt_w);

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_kind == 2'd3) |=> rel_err_o);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core_chk
    p_ceiling_r3: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[c] |-> (int'(core_count_o[c*NW +: NW]) < MAX_PARTS));
    p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
      int'(core_count_o[c*NW +: NW]) >= MIN_PARTS);
  end

  for (genvar p = 0; p < NUM_PARTS; p++) begin : g_part_chk
    p_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(part_sel_o[p*NUM_CORES +: NUM_CORES]) == 32'(owner_valid_o[p]));
  end

endmodule

bind pool_partition_alloc pool_alloc_chk #(
  .NUM_CORES (NUM_CORES),
  .NUM_PARTS (NUM_PARTS),
  .MIN_PARTS (MIN_PARTS),
  .MAX_PARTS (MAX_PARTS)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .grant_o       (grant_o),
  .grant_part_o  (grant_part_o),
  .owner_valid_o (owner_valid_o),
  .owner_o       (owner_o),
  .part_sel_o    (part_sel_o),
  .core_count_o  (core_count_o),
  .free_count_o  (free_count_o),
  .rel_err_o     (rel_err_o),
  .scan_cnt_w    (scan_cnt_w),
  .rel_kind      (rel_kind)
);

// File: tb/sim_pool_partition_alloc.sv
module sim_pool_partition_alloc;
  localparam int CLK_PERIOD = 10;
  localparam int NC  = 4;
  localparam int NP  = 16;
  localparam int MIN = 2;
  localparam int MAX = 6;
  localparam int CW  = $clog2(NC);
  localparam int PW  = $clog2(NP);
  localparam int NW  = $clog2(NP + 1);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NC-1:0]     req = '0;
  logic              rel_v = 1'b0;
  logic [CW-1:0]     rel_c = '0;
  logic [PW-1:0]     rel_p = '0;
  logic [NC-1:0]     grant;
  logic [PW-1:0]     grant_part;
  logic [NP-1:0]     own_vld;
  logic [NP*CW-1:0]  owner;
  logic [NP*NC-1:0]  sel;
  logic [NC*NW-1:0]  counts;
  logic [NW-1:0]     free_cnt;
  logic              rel_err;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pool_partition_alloc #(
    .NUM_CORES(NC), .NUM_PARTS(NP), .MIN_PARTS(MIN), .MAX_PARTS(MAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rel_valid_i(rel_v),
    .rel_core_i(rel_c), .rel_part_i(rel_p), .grant_o(grant),
    .grant_part_o(grant_part), .owner_valid_o(own_vld), .owner_o(owner),
    .part_sel_o(sel), .core_count_o(counts), .free_count_o(free_cnt),
    .rel_err_o(rel_err)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int own_of(input int p);
    return int'(owner[p*CW +: CW]);
  endfunction

  function automatic int cnt_of(input int c);
    return int'(counts[c*NW +: NW]);
  endfunction

  function automatic int gnt_core();
    int r;
    r = -1;
    for (int c = NC - 1; c >= 0; c--) if (grant[c]) r = c;
    if ($countones(grant) > 1) r = 99;
    return r;
  endfunction

  function automatic int sel_of(input int p);
    return int'(sel[p*NC +: NC]);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic t_reset();
    for (int c = 0; c < NC; c++) check($sformatf("R1 count core %0d", c), cnt_of(c), MIN);
    check("R1 free count", int'(free_cnt), NP - NC * MIN);
    for (int p = 0; p < NP; p++) begin
      check($sformatf("R1 valid part %0d", p), int'(own_vld[p]), (p < NC * MIN) ? 1 : 0);
      if (p < NC * MIN) check($sformatf("R1 owner part %0d", p), own_of(p), p / MIN);
    end
    check("R11 sel part 3", sel_of(3), 2);
    check("R11 sel free part 8", sel_of(8), 0);
    check("R2 no grant idle", int'(grant), 0);
  endtask

  task automatic t_single_grant();
    req = 4'b0010;
    #1;
    check("R2 grant core", gnt_core(), 1);
    check("R2 grant lowest free", int'(grant_part), 8);
    tick();
    req = '0;
    check("R2 part 8 owned", int'(own_vld[8]), 1);
    check("R2 part 8 owner", own_of(8), 1);
    check("R2 core1 count", cnt_of(1), 3);
    check("R10 free after grant", int'(free_cnt), 7);
  endtask

  task automatic t_round_robin();
    int exp_core[4] = '{2, 3, 0, 1};
    req = '1;
    for (int i = 0; i < 4; i++) begin
      #1;
      check($sformatf("R5 winner step %0d", i), gnt_core(), exp_core[i]);
      check($sformatf("R2 part step %0d", i), int'(grant_part), 9 + i);
      tick();
    end
    req = '0;
    check("R10 free after rotation", int'(free_cnt), 3);
    check("R5 core1 count", cnt_of(1), 4);
  endtask

  task automatic t_ceiling_and_empty();
    req = 4'b0010;
    for (int i = 0; i < 2; i++) begin
      #1;
      check("R2 ceiling run core", gnt_core(), 1);
      check("R2 ceiling run part", int'(grant_part), 13 + i);
      tick();
    end
    check("R3 core1 at max", cnt_of(1), MAX);
    #1;
    check("R3 no grant at max", int'(grant), 0);
    tick();
    check("R3 count held", cnt_of(1), MAX);
    req = 4'b0100;
    #1;
    check("R2 last free to core2", int'(grant_part), 15);
    tick();
    check("R4 pool empty", int'(free_cnt), 0);
    req = 4'b0001;
    #1;
    check("R4 no grant when empty", int'(grant), 0);
    tick();
    req = '0;
    check("R4 core0 unchanged", cnt_of(0), 3);
  endtask

  task automatic t_release();
    rel_v = 1'b1; rel_c = 2'd1; rel_p = 4'd13;
    tick();
    rel_v = 1'b0;
    check("R6 part 13 freed", int'(own_vld[13]), 0);
    check("R6 core1 count", cnt_of(1), 5);
    check("R6 free count", int'(free_cnt), 1);
    check("R6 no error", int'(rel_err), 0);
  endtask

  task automatic t_release_with_grant();
    rel_v = 1'b1; rel_c = 2'd1; rel_p = 4'd14;
    req = 4'b0001;
    #1;
    check("R9 grant core0", gnt_core(), 0);
    check("R9 grant not released part", int'(grant_part), 13);
    tick();
    rel_v = 1'b0; req = '0;
    check("R9 part 13 to core0", own_of(13), 0);
    check("R9 part 14 freed", int'(own_vld[14]), 0);
    check("R9 core0 count", cnt_of(0), 4);
    check("R9 core1 count", cnt_of(1), 4);
    check("R9 free count", int'(free_cnt), 1);
    check("R11 sel part 13", sel_of(13), 1);
    check("R11 sel part 14", sel_of(14), 0);
  endtask

  task automatic t_floor();
    rel_v = 1'b1; rel_c = 2'd3; rel_p = 4'd10;
    tick();
    check("R6 core3 down to floor", cnt_of(3), MIN);
    check("R6 free after core3 release", int'(free_cnt), 2);
    rel_p = 4'd6;
    tick();
    rel_v = 1'b0;
    check("R7 part 6 kept", int'(own_vld[6]), 1);
    check("R7 part 6 owner", own_of(6), 3);
    check("R7 core3 count", cnt_of(3), MIN);
    check("R7 free unchanged", int'(free_cnt), 2);
    check("R7 no error", int'(rel_err), 0);
  endtask

  task automatic t_bad_release();
    rel_v = 1'b1; rel_c = 2'd0; rel_p = 4'd15;
    tick();
    rel_v = 1'b0;
    check("R8 error raised", int'(rel_err), 1);
    check("R8 part 15 owner kept", own_of(15), 2);
    check("R8 core0 count", cnt_of(0), 4);
    check("R8 core2 count", cnt_of(2), 4);
    check("R8 free unchanged", int'(free_cnt), 2);
    tick();
    check("R8 error one cycle", int'(rel_err), 0);
    rel_v = 1'b1; rel_c = 2'd2; rel_p = 4'd14;
    tick();
    rel_v = 1'b0;
    check("R8 error on free part", int'(rel_err), 1);
    check("R8 free part stays free", int'(own_vld[14]), 0);
    check("R8 free count kept", int'(free_cnt), 2);
    tick();
    check("R8 error cleared", int'(rel_err), 0);
  endtask

  task automatic t_balance();
    int sum;
    sum = int'(free_cnt);
    for (int c = 0; c < NC; c++) sum += cnt_of(c);
    check("R10 counts plus free", sum, NP);
    check("R10 free matches map", int'(free_cnt), NP - $countones(own_vld));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    @(negedge clk);
    t_single_grant();
    t_round_robin();
    t_ceiling_and_empty();
    t_release();
    t_release_with_grant();
    t_floor();
    t_bad_release();
    t_balance();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule